// File: doc/BRIEF.md
# UART Automatic Hardware Flow Control

This block handles the hardware handshake lines for a UART that has a 16-entry receive FIFO and a transmitter. On the receive side it compares the FIFO fill count against a trigger level that software selects. It drives the active-low request-to-send line with two-level hysteresis. It also raises a receive-trigger interrupt. On the transmit side it synchronizes the incoming active-low clear-to-send pin and uses it to hold off the start of each new character.

The transmitter asks for permission through `tx_start_req` and begins a character only when `tx_start_ok` is high. A character that has already started is never cut short, because the block gates only this start handshake. Software writes one configuration word through a load strobe. The word holds two independent enables (automatic RTS and automatic CTS), a manual RTS bit and a 2-bit trigger selector.

The trigger selector picks a rung on a ladder of fill levels: 0, 1, 4, 8, 14, 16. Selector value `s` uses rung `s+1` as the trigger level. RTS is dropped (pin driven to 1) at rung `s+2`. RTS is raised again only below rung `s`, where a rung of 0 means the FIFO is empty.

Top module: `uart_hw_flowctl`

## Requirements
- R1: After reset both automatic features are off, the manual RTS bit is 0 and the selector is 0, so `rts_n_pin` is 1, `rx_trig_irq` is 0 and `tx_start_ok` equals `tx_start_req`.
- R2: With automatic CTS on, `tx_start_ok` is 0 whenever `cts_n_pin`, seen through a two-flop synchronizer, is 1. Otherwise it equals `tx_start_req`. A pin change therefore reaches `tx_start_ok` after two rising clock edges.
- R3: With automatic CTS off, `cts_n_pin` has no effect on `tx_start_ok`.
- R4: With automatic RTS on, `rts_n_pin` goes to 1 one cycle after `rx_fill` reaches the stop level. The stop level is 4, 8, 14 or 16 for selector values 0, 1, 2 and 3.
- R5: Once `rts_n_pin` is 1 under automatic RTS, it stays 1 until `rx_fill` falls below the release level (1, 1, 4 or 8 for selector 0 to 3). It then returns to 0 one cycle later. Fill values between the two levels never change it.
- R6: With automatic RTS off, `rts_n_pin` is the inverse of the manual RTS bit. Turning the feature off also clears the held stop state.
- R7: With automatic RTS on, `rx_trig_irq` is 1 one cycle after `rx_fill` is at or above the trigger level (1, 4, 8 or 14 for selector 0 to 3). It clears by itself one cycle after the fill drops below that level. With automatic RTS off it is 0.
- R8: The configuration is captured on a rising edge where `cfg_load` is 1 and acts from the following cycle. At other times it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Captures the configuration fields below |
| cfg_auto_rts | input | 1 | Enable for automatic RTS and the trigger interrupt |
| cfg_auto_cts | input | 1 | Enable for CTS gating of transmit starts |
| cfg_sw_rts | input | 1 | Manual RTS request; the pin is its inverse when automatic RTS is off |
| cfg_trig_sel | input | 2 | Trigger selector: 0..3 gives levels 1, 4, 8, 14 |
| rx_fill | input | FILL_W (5) | Receive FIFO occupancy, 0 to 16 |
| cts_n_pin | input | 1 | Asynchronous clear-to-send pin; 1 asks the transmitter to pause |
| tx_start_req | input | 1 | Transmitter wants to begin a new character |
| tx_start_ok | output | 1 | Permission to begin that character |
| rts_n_pin | output | 1 | Request-to-send pin; 1 asks the far end to pause |
| rx_trig_irq | output | 1 | Receive-trigger interrupt flag |

## Verification
The assertions assume that `rx_fill` never exceeds the FIFO depth. They also assume that the configuration fields are stable whenever `cfg_load` is high at a clock edge. The bench drives every input just after a falling edge and keeps the fill count in 0..16. It sweeps the fill up and down through every selector setting and parks the fill between the two hysteresis levels. While the synchronizer is settling it toggles the CTS pin only with the feature both on and off. Because `cfg_load` is held low throughout reset, the manual-RTS assertion never sees a load that was taken during reset.

// File: rtl/uflow_pkg.sv
`timescale 1ns/1ps
package uflow_pkg;

  localparam int unsigned DEF_DEPTH = 16;

  typedef enum logic [1:0] {
    TRIG_SEL_0 = 2'd0,
    TRIG_SEL_1 = 2'd1,
    TRIG_SEL_2 = 2'd2,
    TRIG_SEL_3 = 2'd3
  } trig_sel_e;

  typedef struct packed {
    logic      auto_rts;
    logic      auto_cts;
    logic      sw_rts;
    trig_sel_e sel;
  } flow_cfg_t;

  // Fill-level ladder; the selector indexes it at sel, sel+1 and sel+2.
  function automatic int unsigned rung(input int unsigned depth, input int unsigned idx);
    int unsigned lvl;
    case (idx)
      0:       lvl = 0;
      1:       lvl = 1;
      2:       lvl = depth / 4;
      3:       lvl = depth / 2;
      4:       lvl = depth - 2;
      default: lvl = depth;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/uflow_sync_chain.sv
`timescale 1ns/1ps
module uflow_sync_chain #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg_d;
  logic [STAGES-1:0] stg_q;

  assign stg_d[0] = d;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      assign stg_d[i] = stg_q[i-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/uflow_cfg_reg.sv
`timescale 1ns/1ps
module uflow_cfg_reg
  import uflow_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  flow_cfg_t cfg_d,
  output flow_cfg_t cfg_q
);

  flow_cfg_t cfg_nxt;

  always_comb begin
    cfg_nxt = cfg_q;
    if (load) begin
      cfg_nxt = cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{auto_rts: 1'b0, auto_cts: 1'b0, sw_rts: 1'b0, sel: TRIG_SEL_0};
    end else begin
      cfg_q <= cfg_nxt;
    end
  end

  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cfg_q == $past(cfg_q))); // R8

endmodule

// File: rtl/uflow_rts_hyst.sv
`timescale 1ns/1ps
module uflow_rts_hyst
  import uflow_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  trig_sel_e         sel,
  input  logic [FILL_W-1:0] fill,
  output logic              stop,
  output logic              irq
);

  int unsigned       sel_i;
  int unsigned       rel_raw;
  logic [FILL_W-1:0] trig_lvl;
  logic [FILL_W-1:0] hi_lvl;
  logic [FILL_W-1:0] rel_lvl;
  logic              stop_d;
  logic              irq_d;
  logic              stop_q;
  logic              irq_q;

  // Levels taken from the ladder around the selected rung.
  always_comb begin
    sel_i    = int'(unsigned'(sel));
    trig_lvl = FILL_W'(rung(DEPTH, sel_i + 1));
    hi_lvl   = FILL_W'(rung(DEPTH, sel_i + 2));
    rel_raw  = rung(DEPTH, sel_i);
    rel_lvl  = FILL_W'((rel_raw == 0) ? 1 : rel_raw);
  end

  // Single-flop hysteresis: set at the upper rung, cleared below the lower rung.
  always_comb begin
    stop_d = stop_q;
    if (!en) begin
      stop_d = 1'b0;
    end else if (fill >= hi_lvl) begin
      stop_d = 1'b1;
    end else if (fill < rel_lvl) begin
      stop_d = 1'b0;
    end
    irq_d = en && (fill >= trig_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stop_q <= stop_d;
      irq_q  <= irq_d;
    end
  end

  assign stop = stop_q;
  assign irq  = irq_q;

  AST_STOP_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fill >= hi_lvl) |=> stop); // R4

  AST_NO_CHATTER: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fill >= rel_lvl && fill < hi_lvl) |=> $stable(stop)); // R5

  AST_RELEASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fill < rel_lvl) |=> !stop); // R5

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!stop && !irq)); // R6

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill < trig_lvl) |=> !irq); // R7

endmodule

// File: rtl/uart_hw_flowctl.sv
`timescale 1ns/1ps
module uart_hw_flowctl
  import uflow_pkg::*;
#(
  parameter int unsigned DEPTH       = DEF_DEPTH,
  parameter int unsigned FILL_W      = $clog2(DEPTH + 1),
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic              cfg_auto_rts,
  input  logic              cfg_auto_cts,
  input  logic              cfg_sw_rts,
  input  logic [1:0]        cfg_trig_sel,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic              cts_n_pin,
  input  logic              tx_start_req,
  output logic              tx_start_ok,
  output logic              rts_n_pin,
  output logic              rx_trig_irq
);

  logic      rst_sync_n;
  logic      cts_sync;
  logic      cts_hold;
  logic      rts_stop;
  flow_cfg_t cfg_d;
  flow_cfg_t cfg_q;

  // Reset: asserted asynchronously, released on the clock.
  uflow_sync_chain #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  always_comb begin
    cfg_d.auto_rts = cfg_auto_rts;
    cfg_d.auto_cts = cfg_auto_cts;
    cfg_d.sw_rts   = cfg_sw_rts;
    cfg_d.sel      = trig_sel_e'(cfg_trig_sel);
  end

  uflow_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (cfg_load),
    .cfg_d (cfg_d),
    .cfg_q (cfg_q)
  );

  // CTS pin synchronizer; resets to the pause level.
  uflow_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (cts_n_pin),
    .q     (cts_sync)
  );

  uflow_rts_hyst #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_rts_hyst (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (cfg_q.auto_rts),
    .sel   (cfg_q.sel),
    .fill  (rx_fill),
    .stop  (rts_stop),
    .irq   (rx_trig_irq)
  );

  // Only the start of a character is gated; one in flight is untouched.
  assign cts_hold    = cfg_q.auto_cts & cts_sync;
  assign tx_start_ok = tx_start_req & ~cts_hold;
  assign rts_n_pin   = cfg_q.auto_rts ? rts_stop : ~cfg_q.sw_rts;

  AST_TX_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_start_ok |-> tx_start_req); // R2

  AST_MANUAL_RTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(cfg_load) && !$past(cfg_auto_rts))
      |-> (rts_n_pin == !$past(cfg_sw_rts))); // R6

  AST_LOAD_AUTO_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(cfg_load) && !$past(cfg_auto_rts)) |=> !rx_trig_irq); // R7

endmodule

// File: tb/uart_hw_flowctl_bench.sv
`timescale 1ns/1ps
module uart_hw_flowctl_bench;

  localparam int unsigned FW = 5;

  logic          clk;
  logic          rst_n;
  logic          cfg_load;
  logic          cfg_auto_rts;
  logic          cfg_auto_cts;
  logic          cfg_sw_rts;
  logic [1:0]    cfg_trig_sel;
  logic [FW-1:0] rx_fill;
  logic          cts_n_pin;
  logic          tx_start_req;
  logic          tx_start_ok;
  logic          rts_n_pin;
  logic          rx_trig_irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  typedef struct {
    string tag;
    logic  rts_n;
    logic  irq;
    logic  ok;
  } exp_t;

  exp_t sb[$];

  // Bench-side model state, derived from the requirements.
  logic       m_auto_rts, m_auto_cts, m_sw_rts;
  logic [1:0] m_sel;
  logic       m_stop, m_irq, m_s1, m_s2;

  uart_hw_flowctl u_uart_hw_flowctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_load     (cfg_load),
    .cfg_auto_rts (cfg_auto_rts),
    .cfg_auto_cts (cfg_auto_cts),
    .cfg_sw_rts   (cfg_sw_rts),
    .cfg_trig_sel (cfg_trig_sel),
    .rx_fill      (rx_fill),
    .cts_n_pin    (cts_n_pin),
    .tx_start_req (tx_start_req),
    .tx_start_ok  (tx_start_ok),
    .rts_n_pin    (rts_n_pin),
    .rx_trig_irq  (rx_trig_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int trig_of(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction
  function automatic int hi_of(input logic [1:0] s);
    case (s) 2'd0: return 4; 2'd1: return 8; 2'd2: return 14; default: return 16; endcase
  endfunction
  function automatic int rel_of(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 1; 2'd2: return 4; default: return 8; endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b @%0t", tag, what, act, exp, $time);
    end
  endtask

  // Driver: one clock with the given inputs; pushes the expected outputs.
  task automatic step(input logic ld, input logic a_rts, input logic a_cts, input logic sw,
                      input logic [1:0] sel, input int fill, input logic pin, input logic req,
                      input string tag);
    logic n_stop, n_irq;
    exp_t e;
    @(negedge clk);
    #1;
    cfg_load = ld; cfg_auto_rts = a_rts; cfg_auto_cts = a_cts; cfg_sw_rts = sw;
    cfg_trig_sel = sel; rx_fill = FW'(fill); cts_n_pin = pin; tx_start_req = req;
    @(posedge clk);
    if (!m_auto_rts)                 n_stop = 1'b0;
    else if (fill >= hi_of(m_sel))   n_stop = 1'b1;
    else if (fill < rel_of(m_sel))   n_stop = 1'b0;
    else                             n_stop = m_stop;
    n_irq  = m_auto_rts && (fill >= trig_of(m_sel));
    m_s2   = m_s1;
    m_s1   = pin;
    m_stop = n_stop;
    m_irq  = n_irq;
    if (ld) begin
      m_auto_rts = a_rts; m_auto_cts = a_cts; m_sw_rts = sw; m_sel = sel;
    end
    #1;
    e.tag   = tag;
    e.rts_n = m_auto_rts ? m_stop : !m_sw_rts;
    e.irq   = m_irq;
    e.ok    = req && !(m_auto_cts && m_s2);
    sb.push_back(e);
  endtask

  task automatic idle(input int fill, input logic pin, input logic req, input string tag);
    step(1'b0, cfg_auto_rts, cfg_auto_cts, cfg_sw_rts, cfg_trig_sel, fill, pin, req, tag);
  endtask

  // Monitor: compares at each falling edge before the driver moves inputs.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "rts_n_pin",   rts_n_pin,   e.rts_n);
        chk(e.tag, "rx_trig_irq", rx_trig_irq, e.irq);
        chk(e.tag, "tx_start_ok", tx_start_ok, e.ok);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_auto_rts = 1'b0; cfg_auto_cts = 1'b0;
    cfg_sw_rts = 1'b0; cfg_trig_sel = 2'd0; rx_fill = '0; cts_n_pin = 1'b1; tx_start_req = 1'b1;
    m_auto_rts = 0; m_auto_cts = 0; m_sw_rts = 0; m_sel = 0;
    m_stop = 0; m_irq = 0; m_s1 = 1; m_s2 = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state at the ports.
    chk("R1", "rts_n_pin",   rts_n_pin,   1'b1);
    chk("R1", "rx_trig_irq", rx_trig_irq, 1'b0);
    chk("R1", "tx_start_ok", tx_start_ok, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 R3: defaults hold; CTS pin toggling has no effect while disabled.
    for (int i = 0; i < 6; i++) idle(16, i[0], 1'b1, "R1 R3");
    for (int i = 0; i < 4; i++) idle(0, 1'b1, i[1], "R3");

    // R6 R8: manual RTS bit, loaded and then held.
    step(1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 0, 1'b0, 1'b0, "R6 R8");
    idle(16, 1'b0, 1'b0, "R6 R8");
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 16, 1'b0, 1'b0, "R6 R8");
    idle(16, 1'b0, 1'b0, "R6 R7");

    // R4 R5 R7: sweep fill up and down for each selector.
    for (int s = 0; s < 4; s++) begin
      step(1'b1, 1'b1, 1'b0, 1'b0, 2'(s), 0, 1'b0, 1'b0, "R8 R4");
      for (int f = 0; f <= 16; f++) idle(f, 1'b0, 1'b0, "R4 R7");
      for (int f = 16; f >= 0; f--) idle(f, 1'b0, 1'b0, "R5 R7");
      // R5: park between the levels after a stop, then after a release.
      idle(hi_of(2'(s)), 1'b0, 1'b0, "R5");
      for (int k = 0; k < 4; k++) idle(rel_of(2'(s)) + (k % 2) * (hi_of(2'(s)) - 1 - rel_of(2'(s))), 1'b0, 1'b0, "R5");
      idle(0, 1'b0, 1'b0, "R5");
      for (int k = 0; k < 4; k++) idle(rel_of(2'(s)) + (k % 2) * (hi_of(2'(s)) - 1 - rel_of(2'(s))), 1'b0, 1'b0, "R5");
    end

    // R6: turn automatic RTS off while stopped; manual bit takes over, state cleared.
    idle(16, 1'b0, 1'b0, "R4");
    step(1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 12, 1'b0, 1'b0, "R6");
    idle(12, 1'b0, 1'b0, "R6 R7");
    step(1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 12, 1'b0, 1'b0, "R6");
    idle(12, 1'b0, 1'b0, "R5 R6");

    // R2: automatic CTS gating with synchronizer latency.
    step(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 0, 1'b0, 1'b1, "R2 R8");
    for (int i = 0; i < 3; i++) idle(0, 1'b0, 1'b1, "R2");
    for (int i = 0; i < 4; i++) idle(0, 1'b1, 1'b1, "R2");
    for (int i = 0; i < 4; i++) idle(0, 1'b0, i[0], "R2");
    for (int i = 0; i < 10; i++) idle(0, (i % 3) == 0, 1'b1, "R2");
    // R3: switch CTS gating off while pin says pause.
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 0, 1'b1, 1'b1, "R3 R8");
    for (int i = 0; i < 4; i++) idle(0, 1'b1, 1'b1, "R3");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule